// File: doc/BRIEF.md
# DMA Termination and Status Controller

This block ends a transfer between two buses and reports how it ended. Software loads the start addresses' low bits, a byte length and a direction flag, then pulses GO. The controller checks the programming, raises its active flag, and paces a source read port and a destination write port. Each accepted read moves one beat into an intermediate buffer, which is modelled only by its fill level. Each accepted write takes one beat out of it. The read and write engines are outside the block and are reached through simple request/acknowledge/error pins.

A transfer ends in exactly one of six ways: normal completion, software stop, software halt, a local-bus error, a remote-bus error, or a programming fault. The two kinds of bus error are handled differently. When a source read fails, reads stop at once, but the buffer keeps draining to the destination, and the status is posted only after the buffer is empty. When a destination write fails, both sides stop in that same cycle and the status is posted at once.

A remaining-byte count follows the source side only. After a destination failure, the true failure point can therefore lie up to one buffer's worth of bytes before the point this count implies. Each end cause has its own interrupt enable, and all enabled causes share one interrupt line.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset the active flag, the status bits, the interrupt and both request lines are low. A GO accepted while idle raises the active flag on the next edge, and the flag falls on the edge where the end status is posted. No read or write request is made while idle.
- R2: A GO is refused when bus mastership is disabled, or when the low address bits (below the beat size) of the source and destination differ. A refused GO sets only the protocol-fault status bit (bit 5), starts no transfer and leaves the active flag low.
- R3: The status field uses these bits: bit 0 done, bit 1 stop, bit 2 halt, bit 3 local-bus error, bit 4 remote-bus error, bit 5 protocol fault. An accepted GO clears the field, and every end of a transfer sets exactly one bit.
- R4: When all programmed bytes have been read and the buffer has drained with no stop, halt or error, the done bit is set and the remaining count is zero.
- R5: On a source read error, no further read request is made. Buffered beats are still written, and the error bit is posted only after the fill level reaches zero.
- R6: On a destination write error, the read and write requests both drop and the error bit is posted on the same edge. The fill level keeps the unwritten amount.
- R7: The direction flag is captured at GO; when set, the source is on the local bus. An error on the local-bus side sets bit 3, and an error on the remote-bus side sets bit 4.
- R8: The remaining count is loaded with the length at GO. It falls by one beat for each accepted source read and changes for nothing else.
- R9: The fill level never exceeds the buffer size. No read is requested unless a whole beat of space is free.
- R10: A stop request stops reads at the next beat boundary. After the buffer drains, the stop bit is set, unless all bytes had already been read, in which case done is set.
- R11: A halt request lets reads continue up to the next command-packet boundary (every PKT_BEATS beats from the start). After the buffer drains, the halt bit is set.
- R12: The interrupt output is registered. It is high exactly when some status bit is set whose enable was high on the previous edge.
- R13: Writing a one to a clear bit clears that status bit. A GO received while the active flag is high is ignored and leaves the count and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse |
| master_en | input | 1 | Bus mastership enabled |
| src_local | input | 1 | 1: source on local bus, destination on remote bus |
| src_lo | input | ALIGN_W | Low bits of source start address |
| dst_lo | input | ALIGN_W | Low bits of destination start address |
| xfer_len | input | CNT_W | Transfer length in bytes (whole beats) |
| stop_req | input | 1 | Stop at next beat boundary |
| halt_req | input | 1 | Halt at next packet boundary |
| rd_req | output | 1 | Source read beat request |
| rd_ack | input | 1 | Source read beat accepted |
| rd_err | input | 1 | Source read failed |
| wr_req | output | 1 | Destination write beat request |
| wr_ack | input | 1 | Destination write beat accepted |
| wr_err | input | 1 | Destination write failed |
| int_en | input | 6 | Per-cause interrupt enables |
| stat_clr | input | 6 | Write-one-to-clear strobes for status |
| active | output | 1 | Transfer running |
| status | output | 6 | End-of-transfer status bits |
| remain | output | CNT_W | Bytes not yet read from the source |
| level | output | OCC_W | Buffer fill in bytes |
| irq | output | 1 | Merged interrupt request |

## Verification
The properties assume that acknowledge and error pins are only meaningful in cycles where the matching request is high. They also assume the length is a whole number of beats and that a failing beat is never acknowledged as good. The bench responders derive rd_ack, rd_err, wr_ack and wr_err by ANDing the request with knobs set at the falling edge, so no response appears without a request. Every programmed length is a multiple of eight bytes, and each error knob is armed for exactly one requested beat.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  localparam int ST_W = 6;

  // status bit index of each end cause
  typedef enum logic [2:0] {
    END_DONE = 3'd0,
    END_STOP = 3'd1,
    END_HALT = 3'd2,
    END_LERR = 3'd3,
    END_VERR = 3'd4,
    END_PERR = 3'd5
  } end_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_DRAIN = 2'd2
  } st_e;
endpackage

// File: rtl/dma_go_check.sv
module dma_go_check #(
  parameter int ALIGN_W = 3
) (
  input  logic               master_en,
  input  logic [ALIGN_W-1:0] src_lo,
  input  logic [ALIGN_W-1:0] dst_lo,
  output logic               prog_ok
);
  // both ends must share the same offset inside a beat
  assign prog_ok = master_en && (src_lo == dst_lo);
endmodule

// File: rtl/dma_flow_track.sv
module dma_flow_track #(
  parameter int CNT_W      = 24,
  parameter int OCC_W      = 10,
  parameter int BEAT_BYTES = 8,
  parameter int FIFO_BYTES = 512,
  parameter int PKT_BEATS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             rd_fire,
  input  logic             wr_fire,
  output logic [CNT_W-1:0] remain,
  output logic [OCC_W-1:0] level,
  output logic             pkt_edge,
  output logic             room
);
  localparam int PK_W = (PKT_BEATS > 1) ? $clog2(PKT_BEATS) : 1;
  localparam logic [OCC_W-1:0] BEAT_O  = OCC_W'(BEAT_BYTES);
  localparam logic [CNT_W-1:0] BEAT_C  = CNT_W'(BEAT_BYTES);
  localparam logic [OCC_W-1:0] ROOM_LIM = OCC_W'(FIFO_BYTES - BEAT_BYTES);
  localparam logic [PK_W-1:0]  PK_LAST  = PK_W'(PKT_BEATS - 1);

  logic [PK_W-1:0] pkt_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      level   <= '0;
      pkt_cnt <= '0;
    end else if (load) begin
      remain  <= len;
      level   <= '0;
      pkt_cnt <= '0;
    end else begin
      if (rd_fire) begin
        remain  <= remain - BEAT_C;
        pkt_cnt <= (pkt_cnt == PK_LAST) ? '0 : pkt_cnt + 1'b1;
      end
      case ({rd_fire, wr_fire})
        2'b10:   level <= level + BEAT_O;
        2'b01:   level <= level - BEAT_O;
        default: level <= level;
      endcase
    end
  end

  assign pkt_edge = (pkt_cnt == '0);
  assign room     = (level <= ROOM_LIM);
endmodule

// File: rtl/dma_status_irq.sv
module dma_status_irq
  import dma_term_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_all,
  input  logic            post,
  input  end_e            cause,
  input  logic [ST_W-1:0] w1c,
  input  logic [ST_W-1:0] int_en,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] st_d;

  always_comb begin
    st_d = status & ~w1c;
    if (clear_all) st_d = '0;
    if (post)      st_d = ST_W'(1) << cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_d;
      irq    <= |(st_d & int_en);
    end
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int BEAT_BYTES = 8,
  parameter int FIFO_BYTES = 512,
  parameter int PKT_BEATS  = 4,
  localparam int ALIGN_W   = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1,
  localparam int OCC_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               master_en,
  input  logic               src_local,
  input  logic [ALIGN_W-1:0] src_lo,
  input  logic [ALIGN_W-1:0] dst_lo,
  input  logic [CNT_W-1:0]   xfer_len,
  input  logic               stop_req,
  input  logic               halt_req,
  output logic               rd_req,
  input  logic               rd_ack,
  input  logic               rd_err,
  output logic               wr_req,
  input  logic               wr_ack,
  input  logic               wr_err,
  input  logic [ST_W-1:0]    int_en,
  input  logic [ST_W-1:0]    stat_clr,
  output logic               active,
  output logic [ST_W-1:0]    status,
  output logic [CNT_W-1:0]   remain,
  output logic [OCC_W-1:0]   level,
  output logic               irq
);
  st_e  st;
  logic stop_q, halt_q, loc_q;
  logic prog_ok, start, refuse;
  logic pkt_edge, room;
  logic rd_fire, wr_fire, src_fail, dst_fail, finish, post;
  end_e cause;

  dma_go_check #(.ALIGN_W(ALIGN_W)) u_chk_go (
    .master_en(master_en), .src_lo(src_lo), .dst_lo(dst_lo), .prog_ok(prog_ok)
  );

  assign active = (st != S_IDLE);
  assign start  = go && !active && prog_ok;
  assign refuse = go && !active && !prog_ok;

  // requests are decoded from registered state only
  assign rd_req = (st == S_RUN) && (remain != '0) && room && !stop_q
                  && !(halt_q && pkt_edge);
  assign wr_req = active && (level != '0);

  assign src_fail = rd_req && rd_err;
  assign dst_fail = wr_req && wr_err;
  assign rd_fire  = rd_req && rd_ack && !rd_err;
  assign wr_fire  = wr_req && wr_ack && !wr_err;
  assign finish   = active && !rd_req && (level == '0);
  assign post     = refuse || dst_fail || finish;

  dma_flow_track #(
    .CNT_W(CNT_W), .OCC_W(OCC_W), .BEAT_BYTES(BEAT_BYTES),
    .FIFO_BYTES(FIFO_BYTES), .PKT_BEATS(PKT_BEATS)
  ) u_flow (
    .clk(clk), .rst(rst), .load(start), .len(xfer_len),
    .rd_fire(rd_fire), .wr_fire(wr_fire),
    .remain(remain), .level(level), .pkt_edge(pkt_edge), .room(room)
  );

  // end cause, highest priority first
  always_comb begin
    if (refuse)              cause = END_PERR;
    else if (dst_fail)       cause = loc_q ? END_VERR : END_LERR;
    else if (st == S_DRAIN)  cause = loc_q ? END_LERR : END_VERR;
    else if (remain == '0)   cause = END_DONE;
    else if (stop_q)         cause = END_STOP;
    else                     cause = END_HALT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      stop_q <= 1'b0;
      halt_q <= 1'b0;
      loc_q  <= 1'b0;
    end else if (start) begin
      st     <= S_RUN;
      stop_q <= 1'b0;
      halt_q <= 1'b0;
      loc_q  <= src_local;
    end else if (active) begin
      if (stop_req) stop_q <= 1'b1;
      if (halt_req) halt_q <= 1'b1;
      if (dst_fail || finish) st <= S_IDLE;
      else if (src_fail)      st <= S_DRAIN;
    end
  end

  dma_status_irq u_stat (
    .clk(clk), .rst(rst), .clear_all(start), .post(post), .cause(cause),
    .w1c(stat_clr), .int_en(int_en), .status(status), .irq(irq)
  );
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int CNT_W      = 24,
  parameter int OCC_W      = 10,
  parameter int FIFO_BYTES = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic             rd_req,
  input logic             rd_ack,
  input logic             rd_err,
  input logic             wr_req,
  input logic             wr_err,
  input logic [5:0]       status,
  input logic [CNT_W-1:0] remain,
  input logic [OCC_W-1:0] level,
  input logic [5:0]       int_en,
  input logic             irq
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= OCC_W'(FIFO_BYTES)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!rd_req && !wr_req)); // R1
  AST_SRC_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && rd_req && rd_err && !(wr_req && wr_err)) |=> !rd_req); // R5
  AST_DST_ERR_STOP: assert property (@(posedge clk) disable iff (rst)
    (active && wr_req && wr_err) |=> (!active && !rd_req && !wr_req)); // R6
  AST_REMAIN_SRC_ONLY: assert property (@(posedge clk) disable iff (rst)
    (active && !(rd_req && rd_ack && !rd_err)) |=> $stable(remain)); // R8
  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & $past(int_en))); // R12
endmodule

bind dma_term_ctrl dma_term_chk #(
  .CNT_W(CNT_W), .OCC_W(OCC_W), .FIFO_BYTES(FIFO_BYTES)
) u_prop (
  .clk(clk), .rst(rst), .active(active), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_err(rd_err), .wr_req(wr_req), .wr_err(wr_err), .status(status),
  .remain(remain), .level(level), .int_en(int_en), .irq(irq)
);

// File: tb/dma_term_ctrl_test.sv
`timescale 1ns/1ps
module dma_term_ctrl_test;
  localparam int CNT_W = 24;
  localparam int OCC_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic go = 0, master_en = 1, src_local = 1, stop_req = 0, halt_req = 0;
  logic [2:0] src_lo = 0, dst_lo = 0;
  logic [CNT_W-1:0] xfer_len = 0;
  logic [5:0] int_en = 6'h3f, stat_clr = 0;
  logic src_go = 0, dst_go = 0, src_err_arm = 0, dst_err_arm = 0;
  logic rd_req, wr_req, rd_ack, rd_err, wr_ack, wr_err, active, irq;
  logic [5:0] status;
  logic [CNT_W-1:0] remain;
  logic [OCC_W-1:0] level;

  // bus responders: never answer without a request
  assign rd_ack = rd_req & src_go;
  assign rd_err = rd_req & src_err_arm;
  assign wr_ack = wr_req & dst_go;
  assign wr_err = wr_req & dst_err_arm;

  dma_term_ctrl uut (
    .clk(clk), .rst(rst), .go(go), .master_en(master_en), .src_local(src_local),
    .src_lo(src_lo), .dst_lo(dst_lo), .xfer_len(xfer_len),
    .stop_req(stop_req), .halt_req(halt_req),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_err(rd_err),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_err(wr_err),
    .int_en(int_en), .stat_clr(stat_clr), .active(active), .status(status),
    .remain(remain), .level(level), .irq(irq)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [5:0]       st;
    logic [CNT_W-1:0] rem;
    logic [OCC_W-1:0] lvl;
    bit               counts;
    string            tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_end(logic [5:0] st, logic [CNT_W-1:0] rem,
                            logic [OCC_W-1:0] lvl, bit counts, string tag);
    exp_t e;
    e.st = st; e.rem = rem; e.lvl = lvl; e.counts = counts; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: every newly posted status is compared with the queue head
  logic [5:0] prev_st = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (status != prev_st && status != 0) begin
        if (sb.size() == 0) begin
          check("R3 unexpected status", {26'd0, status}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " status"}, {26'd0, status}, {26'd0, e.st});
          if (e.counts) begin
            check({e.tag, " remain"}, 32'(remain), 32'(e.rem));
            check({e.tag, " level"}, 32'(level), 32'(e.lvl));
          end
        end
      end
      prev_st = status;
    end
  end

  task automatic pulse_go(logic [CNT_W-1:0] len);
    @(negedge clk); xfer_len = len; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic clear_status(logic [5:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = 0;
  endtask

  task automatic wait_idle();
    while (active) @(negedge clk);
  endtask

  task automatic beat_src(int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (rd_req) begin src_go = 1; k++; end
      else src_go = 0;
    end
    @(negedge clk); src_go = 0;
  endtask

  task automatic src_error();
    @(negedge clk);
    while (!rd_req) @(negedge clk);
    src_err_arm = 1;
    @(negedge clk); src_err_arm = 0;
  endtask

  task automatic dst_error();
    @(negedge clk);
    while (!wr_req) @(negedge clk);
    dst_err_arm = 1;
    @(negedge clk); dst_err_arm = 0;
  endtask

  task automatic finish_run();
    if (sb.size() != 0) check("R3 missing end status", 32'(sb.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset active", active, 0);
    check("R1 reset status", status, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset rd_req", rd_req, 0);

    // R2: mastership disabled
    master_en = 0;
    expect_end(6'b100000, 0, 0, 0, "R2 no mastership");
    pulse_go(64);
    check("R2 not active", active, 0);
    master_en = 1;
    clear_status(6'h3f);
    check("R13 w1c cleared", status, 0);
    // R2: misaligned ends
    src_lo = 3'd1; dst_lo = 3'd2;
    expect_end(6'b100000, 0, 0, 0, "R2 misaligned");
    pulse_go(64);
    src_lo = 0; dst_lo = 0;
    clear_status(6'h3f);

    // R4: normal completion, free-running both sides
    src_go = 1; dst_go = 1;
    expect_end(6'b000001, 0, 0, 1, "R4 done");
    pulse_go(64);
    check("R1 active after go", active, 1);
    wait_idle();
    @(negedge clk);
    check("R12 irq on done", irq, 1);
    src_go = 0; dst_go = 0;
    clear_status(6'h3f);
    check("R12 irq after clear", irq, 0);

    // R5 + R7: source error on local bus, drain before status
    src_local = 1;
    expect_end(6'b001000, 104, 0, 1, "R5 src err local");
    pulse_go(128);
    beat_src(3);
    check("R8 remain after 3 beats", 32'(remain), 104);
    src_error();
    repeat (3) @(negedge clk);
    check("R5 reads stopped", rd_req, 0);
    check("R5 status held while buffered", status, 0);
    check("R5 level kept", 32'(level), 24);
    dst_go = 1;
    wait_idle();
    dst_go = 0;
    clear_status(6'h3f);

    // R7: source error on remote bus
    src_local = 0;
    expect_end(6'b010000, 64, 0, 1, "R7 src err remote");
    pulse_go(64);
    src_error();
    wait_idle();
    clear_status(6'h3f);

    // R6: destination error stops both sides at once
    src_local = 1;
    expect_end(6'b010000, 112, 16, 1, "R6 dst err");
    pulse_go(128);
    beat_src(2);
    dst_error();
    check("R6 inactive", active, 0);
    check("R6 rd_req low", rd_req, 0);
    clear_status(6'h3f);

    // R10 + R12 masking: stop
    int_en = 6'b000001;
    expect_end(6'b000010, 112, 0, 1, "R10 stop");
    pulse_go(128);
    beat_src(2);
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0; dst_go = 1;
    wait_idle();
    @(negedge clk);
    check("R12 masked irq", irq, 0);
    int_en = 6'b000010;
    @(negedge clk);
    check("R12 irq after enable", irq, 1);
    clear_status(6'b000010);
    check("R13 stop cleared", status, 0);
    check("R12 irq dropped", irq, 0);
    int_en = 6'h3f;
    dst_go = 0;

    // R11: halt mid-packet runs to the packet boundary
    expect_end(6'b000100, 96, 0, 1, "R11 halt");
    pulse_go(128);
    beat_src(1);
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0; src_go = 1; dst_go = 1;
    wait_idle();
    src_go = 0; dst_go = 0;
    clear_status(6'h3f);

    // R9 + R13: buffer fills, busy GO ignored
    src_go = 1;
    expect_end(6'b000001, 0, 0, 1, "R9 full then done");
    pulse_go(1024);
    repeat (80) @(negedge clk);
    check("R9 level at depth", 32'(level), 512);
    check("R9 no read when full", rd_req, 0);
    check("R8 remain at full", 32'(remain), 512);
    pulse_go(8);
    @(negedge clk);
    check("R13 busy go ignored", 32'(remain), 512);
    check("R13 busy status", status, 0);
    dst_go = 1;
    wait_idle();
    src_go = 0; dst_go = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule